// File: doc/BRIEF.md
# Teletext Bit Request and Capture Timer

This block pulls a serial teletext bitstream from an external source one bit at a time. At each line start it decides, from the field parity, the line number and two programmable line ranges (one per field), whether the line carries text. On a selected line it waits a programmable number of 27 MHz clocks and then issues a train of one-clock request pulses. The pulses are spaced by a fractional phase accumulator that approximates the bit rate of the chosen standard from the 27 MHz clock. The train stops after exactly the bit count of that standard, and this count includes the clock run-in bits.

For each request, the source must return exactly one new bit. The block samples the bit input a programmable number of clocks after the request, to cover the pipeline latency of the source. It presents the bit with a one-cycle valid flag to a downstream inserter. The start offset is set relative to the line start, which is the leading edge of horizontal sync. The integrator chooses the offset so that the inserted data lands at the position the standard requires once the fixed downstream latency is added.

Top module: `ttx_req_timer`

## Requirements
- R1: While reset is held and after it is released, with no line start seen, `req_o` and `bit_vld_o` are low.
- R2: When `field_odd_i` is 1, a line carries text only if `cfg_odd_first_i <= line_num_i <= cfg_odd_last_i`. Both bounds are inclusive. Line number and field are sampled on the edge where `line_start_i` is high.
- R3: When `field_odd_i` is 0, the even bounds `cfg_even_first_i`/`cfg_even_last_i` are used in the same inclusive way, and the odd bounds are ignored.
- R4: When `cfg_en_i` is 0 at the line start, that line issues no request and raises no valid flag.
- R5: A selected line issues a fixed number of requests, chosen by `cfg_std_i` at the line start: 0 gives 360 (PAL-WST), 1 gives 296 (NTSC-WST), and 2 or 3 give 288 (NABTS). After the last request, `req_o` stays low until the next line start.
- R6: The first request of a selected line rises `cfg_hstart_i + 1` clock edges after the edge that samples `line_start_i`.
- R7: Every request pulse is one clock wide. The distance between successive rising edges is 3 or 4 clocks for code 0 (about 6.94 Mbit/s). For the other codes it is 4 or 5 clocks (about 5.73 Mbit/s).
- R8: For a request that rose after edge E, `bit_o` takes the value of `ttx_i` sampled on edge E + `cfg_delay_i`, and `bit_vld_o` is high for the one cycle that follows. A delay of 0 acts as 1. There is one valid flag per request, in request order, including when several requests are in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 27 MHz line-locked clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | One-clock pulse at the leading edge of horizontal sync |
| line_num_i | input | 10 | Line number within the field |
| field_odd_i | input | 1 | 1 in the odd field, 0 in the even field |
| cfg_en_i | input | 1 | Insertion enable |
| cfg_std_i | input | 2 | Standard: 0 PAL-WST, 1 NTSC-WST, 2/3 NABTS |
| cfg_hstart_i | input | 11 | Clocks from line start to the first request |
| cfg_delay_i | input | 4 | Clocks from request to bit sampling |
| cfg_odd_first_i | input | 10 | First text line, odd field |
| cfg_odd_last_i | input | 10 | Last text line, odd field |
| cfg_even_first_i | input | 10 | First text line, even field |
| cfg_even_last_i | input | 10 | Last text line, even field |
| ttx_i | input | 1 | Serial teletext bit from the source |
| req_o | output | 1 | Bit request pulse to the source |
| bit_o | output | 1 | Captured teletext bit |
| bit_vld_o | output | 1 | `bit_o` holds a new bit this cycle |

## Verification
A captured bit's valid flag and a new request pulse can fall in the same cycle when the sampling delay is longer than the request spacing. The bench provokes this with delays of 9 and 15 clocks against spacings of 3 to 5. It drives a pseudo-random bit on every clock and keeps a history of those bits. It queues the cycle of each request and pairs each valid flag with the oldest queued request. For each pair it checks both the arrival cycle and the bit value taken from the history.

// File: rtl/ttx_pkg.sv
package ttx_pkg;
  localparam int WIN_W = 9;

  typedef enum logic [1:0] {
    STD_WST625 = 2'd0,
    STD_WST525 = 2'd1,
    STD_NAB    = 2'd2,
    STD_NAB_B  = 2'd3
  } ttx_std_e;

  function automatic logic [WIN_W-1:0] win_bits(input ttx_std_e s);
    case (s)
      STD_WST625: win_bits = WIN_W'(360);
      STD_WST525: win_bits = WIN_W'(296);
      default:    win_bits = WIN_W'(288);
    endcase
  endfunction
endpackage

// File: rtl/ttx_line_sel.sv
module ttx_line_sel #(
  parameter int LINE_W = 10
) (
  input  logic              en_i,
  input  logic              odd_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [LINE_W-1:0] odd_first_i,
  input  logic [LINE_W-1:0] odd_last_i,
  input  logic [LINE_W-1:0] even_first_i,
  input  logic [LINE_W-1:0] even_last_i,
  output logic              sel_o
);
  logic [LINE_W-1:0] lo, hi;

  always_comb begin
    lo    = odd_i ? odd_first_i : even_first_i;
    hi    = odd_i ? odd_last_i  : even_last_i;
    sel_o = en_i && (line_i >= lo) && (line_i <= hi);
  end
endmodule

// File: rtl/ttx_req_gen.sv
module ttx_req_gen
  import ttx_pkg::*;
#(
  parameter int          HS_W     = 11,
  parameter int          ACC_W    = 16,
  parameter logic [15:0] FAST_INC = 16'd16839,
  parameter logic [15:0] SLOW_INC = 16'd13902
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            line_start_i,
  input  logic            line_ok_i,
  input  ttx_std_e        std_i,
  input  logic [HS_W-1:0] hstart_i,
  output logic            req_o
);
  logic [HS_W-1:0]  hcnt_q;
  logic             armed_q, started_q, train_q;
  logic [WIN_W-1:0] cnt_q, win_q;
  logic [ACC_W-1:0] acc_q, inc_q;
  logic [ACC_W:0]   sum;
  logic             first_fire, carry, fire;

  always_comb begin
    sum        = {1'b0, acc_q} + {1'b0, inc_q};
    carry      = sum[ACC_W];
    first_fire = armed_q && !started_q && (hcnt_q == hstart_i);
    fire       = first_fire || (train_q && carry);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q    <= '0;
      armed_q   <= 1'b0;
      started_q <= 1'b0;
      train_q   <= 1'b0;
      cnt_q     <= '0;
      win_q     <= '0;
      acc_q     <= '0;
      inc_q     <= '0;
      req_o     <= 1'b0;
    end else if (line_start_i) begin
      hcnt_q    <= '0;
      armed_q   <= line_ok_i;
      started_q <= 1'b0;
      train_q   <= 1'b0;
      cnt_q     <= '0;
      win_q     <= win_bits(std_i);
      acc_q     <= '0;
      inc_q     <= (std_i == STD_WST625) ? ACC_W'(FAST_INC) : ACC_W'(SLOW_INC);
      req_o     <= 1'b0;
    end else begin
      if (hcnt_q != '1) hcnt_q <= hcnt_q + 1'b1;
      req_o <= fire;
      if (first_fire) begin
        started_q <= 1'b1;
        train_q   <= (win_q > WIN_W'(1));
        cnt_q     <= win_q - 1'b1;
        acc_q     <= '0;
      end else if (train_q) begin
        acc_q <= sum[ACC_W-1:0];
        if (carry) begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == WIN_W'(1)) train_q <= 1'b0;
        end
      end
    end
  end

  assert_req_one_wide_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);

  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_q |-> (cnt_q != '0) && (cnt_q < win_q));

  assert_no_req_unarmed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !line_start_i) |=> !req_o);

  assert_train_stops_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (train_q && !line_start_i && carry && cnt_q == WIN_W'(1)) |=> !train_q);
endmodule

// File: rtl/ttx_capture.sv
module ttx_capture #(
  parameter int DLY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             ttx_i,
  output logic             bit_o,
  output logic             bit_vld_o
);
  localparam int TAPS = 2 ** DLY_W;

  logic [TAPS-1:1] dly_q;
  logic [TAPS-1:0] taps;
  logic [DLY_W-1:0] sel;
  logic             hit;

  always_comb begin
    taps = {dly_q, req_i};
    sel  = (dly_i == '0) ? '0 : dly_i - 1'b1;
    hit  = taps[sel];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q     <= '0;
      bit_o     <= 1'b0;
      bit_vld_o <= 1'b0;
    end else begin
      dly_q     <= taps[TAPS-2:0];
      bit_vld_o <= hit;
      if (hit) bit_o <= ttx_i;
    end
  end

  assert_short_delay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && dly_i <= DLY_W'(1)) |=> (bit_vld_o || !$stable(dly_i)));
endmodule

// File: rtl/ttx_req_timer.sv
module ttx_req_timer
  import ttx_pkg::*;
#(
  parameter int          LINE_W   = 10,
  parameter int          HS_W     = 11,
  parameter int          DLY_W    = 4,
  parameter int          ACC_W    = 16,
  parameter logic [15:0] FAST_INC = 16'd16839,
  parameter logic [15:0] SLOW_INC = 16'd13902
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic [LINE_W-1:0] line_num_i,
  input  logic              field_odd_i,
  input  logic              cfg_en_i,
  input  logic [1:0]        cfg_std_i,
  input  logic [HS_W-1:0]   cfg_hstart_i,
  input  logic [DLY_W-1:0]  cfg_delay_i,
  input  logic [LINE_W-1:0] cfg_odd_first_i,
  input  logic [LINE_W-1:0] cfg_odd_last_i,
  input  logic [LINE_W-1:0] cfg_even_first_i,
  input  logic [LINE_W-1:0] cfg_even_last_i,
  input  logic              ttx_i,
  output logic              req_o,
  output logic              bit_o,
  output logic              bit_vld_o
);
  logic line_ok;
  logic req;

  ttx_line_sel #(.LINE_W(LINE_W)) u_sel (
    .en_i        (cfg_en_i),
    .odd_i       (field_odd_i),
    .line_i      (line_num_i),
    .odd_first_i (cfg_odd_first_i),
    .odd_last_i  (cfg_odd_last_i),
    .even_first_i(cfg_even_first_i),
    .even_last_i (cfg_even_last_i),
    .sel_o       (line_ok)
  );

  ttx_req_gen #(
    .HS_W(HS_W), .ACC_W(ACC_W), .FAST_INC(FAST_INC), .SLOW_INC(SLOW_INC)
  ) u_gen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_start_i(line_start_i),
    .line_ok_i   (line_ok),
    .std_i       (ttx_std_e'(cfg_std_i)),
    .hstart_i    (cfg_hstart_i),
    .req_o       (req)
  );

  ttx_capture #(.DLY_W(DLY_W)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req),
    .dly_i    (cfg_delay_i),
    .ttx_i    (ttx_i),
    .bit_o    (bit_o),
    .bit_vld_o(bit_vld_o)
  );

  assign req_o = req;

  assert_disabled_line_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i && !cfg_en_i) |=> !req_o);
endmodule

// File: tb/sim_ttx_req_timer.sv
module sim_ttx_req_timer;
  localparam int CLK_NS = 37;
  localparam int HN = 1024;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_start = 1'b0;
  logic [9:0] line_num = '0;
  logic       field_odd = 1'b1;
  logic       en = 1'b0;
  logic [1:0] std_sel = 2'd0;
  logic [10:0] hstart = '0;
  logic [3:0] delay = 4'd1;
  logic [9:0] of_q = 10'd7, ol_q = 10'd22, ef_q = 10'd320, el_q = 10'd335;
  logic       ttx = 1'b0;
  logic       req, bit_out, bit_vld;

  int checks = 0, errors = 0;
  int cyc = 0;
  bit hist [HN];
  int rq [$];
  int n_req, n_vld, first_cyc, prev_cyc, gap_lo, gap_hi;
  int wide_err, gap_err, data_err;
  bit prev_req;

  always #(CLK_NS/2) clk = ~clk;

  ttx_req_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .line_start_i(line_start), .line_num_i(line_num),
    .field_odd_i(field_odd), .cfg_en_i(en), .cfg_std_i(std_sel), .cfg_hstart_i(hstart),
    .cfg_delay_i(delay), .cfg_odd_first_i(of_q), .cfg_odd_last_i(ol_q),
    .cfg_even_first_i(ef_q), .cfg_even_last_i(el_q), .ttx_i(ttx),
    .req_o(req), .bit_o(bit_out), .bit_vld_o(bit_vld)
  );

  initial forever @(posedge clk) cyc++;

  // pseudo-random source bit, new value every clock, history kept per cycle
  initial begin : src
    logic [15:0] lfsr = 16'hACE1;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ttx = lfsr[0];
      hist[cyc % HN] = lfsr[0];
    end
  end

  initial forever begin : mon
    @(negedge clk);
    if (req) begin
      if (prev_req) wide_err++;
      else begin
        n_req++;
        if (n_req == 1) first_cyc = cyc;
        else if ((cyc - prev_cyc) < gap_lo || (cyc - prev_cyc) > gap_hi) gap_err++;
        prev_cyc = cyc;
        rq.push_back(cyc);
      end
    end
    prev_req = req;
    if (bit_vld) begin
      n_vld++;
      if (rq.size() == 0) data_err++;
      else begin
        int q, d;
        q = rq.pop_front();
        d = (delay == 0) ? 1 : int'(delay);
        if (cyc != q + d || bit_out != hist[(q + d - 1) % HN]) data_err++;
      end
    end
  end

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // runs one line and checks the request train and every capture
  task automatic run_line(input string tag, input bit odd, input int ln, input int exp_n);
    int s, wait_n;
    n_req = 0; n_vld = 0; first_cyc = -1; prev_cyc = 0;
    wide_err = 0; gap_err = 0; data_err = 0; rq.delete();
    gap_lo = (std_sel == 2'd0) ? 3 : 4;
    gap_hi = gap_lo + 1;
    @(negedge clk);
    field_odd = odd; line_num = 10'(ln); line_start = 1'b1;
    @(negedge clk);
    s = cyc; line_start = 1'b0;
    wait_n = int'(hstart) + 5 * 360 + 40;
    repeat (wait_n) @(negedge clk);
    check(n_req == exp_n, {tag, " request count"}, n_req, exp_n);
    check(n_vld == exp_n, {tag, " R8 valid count"}, n_vld, exp_n);
    check(data_err == 0, {tag, " R8 capture timing/value"}, data_err, 0);
    check(wide_err == 0 && gap_err == 0, {tag, " R7 width/spacing"}, wide_err + gap_err, 0);
    if (exp_n > 0)
      check(first_cyc == s + int'(hstart) + 1, {tag, " R6 first request"}, first_cyc, s + int'(hstart) + 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(req == 0 && bit_vld == 0, "R1 outputs in reset", {req, bit_vld}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(req == 0 && bit_vld == 0, "R1 outputs after reset", {req, bit_vld}, 0);
  endtask

  task automatic t_standards();
    en = 1; delay = 4'd1; hstart = 11'd20;
    std_sel = 2'd0; run_line("R5 std0", 1, 10, 360);
    std_sel = 2'd1; hstart = 11'd0; delay = 4'd3; run_line("R5 std1", 1, 10, 296);
    std_sel = 2'd2; hstart = 11'd100; run_line("R5 std2", 1, 10, 288);
    std_sel = 2'd3; delay = 4'd0; run_line("R5 std3", 1, 10, 288);
  endtask

  task automatic t_overlap();
    std_sel = 2'd0; hstart = 11'd5; delay = 4'd9;
    run_line("R8 in-flight d9", 1, 12, 360);
    std_sel = 2'd1; delay = 4'd15;
    run_line("R8 in-flight d15", 1, 12, 296);
  endtask

  task automatic t_lines();
    std_sel = 2'd1; hstart = 11'd30; delay = 4'd2;
    run_line("R2 odd first", 1, 7, 296);
    run_line("R2 odd last", 1, 22, 296);
    run_line("R2 odd below", 1, 6, 0);
    run_line("R2 odd above", 1, 23, 0);
    run_line("R3 even ignores odd range", 0, 10, 0);
    run_line("R3 even first", 0, 320, 296);
    run_line("R3 even last", 0, 335, 296);
    run_line("R3 even above", 0, 336, 0);
  endtask

  task automatic t_disable();
    en = 0; std_sel = 2'd0;
    run_line("R4 disabled odd", 1, 10, 0);
    run_line("R4 disabled even", 0, 325, 0);
    en = 1;
  endtask

  initial begin
    t_reset();
    t_standards();
    t_overlap();
    t_lines();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule